// File: doc/BRIEF.md
# Indirect-Jump Landing Pad Guard

This block watches the stream of retiring instructions and enforces forward-edge control-flow integrity. Each retired indirect jump arms a "pad expected" state. The next valid retired instruction must then be a landing pad marker. If it is not, the block raises a fault.

The checking depends on three levels of configuration:
- If the extension is absent, pads are harmless hints and nothing is checked.
- If the extension is present but the program has not activated it through its feature word, nothing is checked.
- If the extension is present and activated, the guard is live.

Activation comes from two bits of the feature word. One bit selects unlabeled pads. The other selects pads that carry a function-signature label, which is compared against a label held in a designated register.

The guard produces a registered, single-cycle fault pulse together with a cause code. The surrounding core turns these into an exception. Decoding, label generation, privilege and trap vectoring are handled outside this block.

Top module: `lpad_guard`

## Requirements
- R1: After synchronous reset, `fault` is 0, `fault_cause` is 0, and the pad-expected state is clear, so a non-pad instruction retired first raises no fault.
- R2: While `cfg_present` is 0, no fault is ever raised, whatever the feature word or the retire stream.
- R3: While `cfg_present` is 1 and feature bits 0 and 2 are both 0, no fault is ever raised. Other feature bits, such as bit 1, do not activate checking.
- R4: With checking active, a valid indirect jump followed by a valid non-pad instruction raises `fault` in the cycle after that instruction retires, with `fault_cause` = 1 (missing pad).
- R5: Cycles with `rt_valid` = 0 do not consume the pad-expected state; the check applies to the next valid retired instruction.
- R6: A valid instruction that is not an indirect jump never arms the state, so a non-pad instruction after it raises no fault.
- R7: Under the unlabeled scheme (feature bit 0 set, bit 2 clear), any landing pad satisfies the check, whatever its label and the expected label.
- R8: Under the signature scheme (feature bit 2 set), a pad whose label is nonzero and differs from `exp_label` raises a fault with `fault_cause` = 2 (label mismatch). A pad label equal to `exp_label`, or a pad label of zero, is accepted.
- R9: `fault` lasts exactly one cycle. The state is cleared once the checked instruction retires, so a second non-pad instruction after that raises no fault.
- R10: Deactivating checking (absent, or both scheme bits clear) while the state is armed discards it. A non-pad instruction retired after checking is re-enabled raises no fault.
- R11: When feature bits 0 and 2 are both set, the signature scheme applies.
- R12: `fault_cause` is 0 in every cycle where `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_indirect | input | 1 | The retiring instruction is an indirect jump |
| rt_is_pad | input | 1 | The retiring instruction is a landing pad |
| rt_pad_label | input | LABEL_W | Label field of the retiring pad |
| exp_label | input | LABEL_W | Expected label from the designated register |
| cfg_present | input | 1 | The extension is implemented |
| cfg_feature | input | FEAT_W | Feature word: bit 0 selects unlabeled pads, bit 2 selects signature-labeled pads |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 0 none, 1 missing pad, 2 label mismatch |

## Verification
The bench builds the guard with LABEL_W = 4 and the label check enabled. The narrow label makes random pad labels and expected labels coincide often, and makes zero labels frequent. As a result, the match, the mismatch and the zero-wildcard paths of the signature scheme are all reached many times from random stimulus. The random part also keeps switching the presence flag and the feature word while jumps are pending, which reaches the discard-on-deactivate path and the case where both scheme bits are set.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

    // Feature-word bit positions that select a pad scheme.
    localparam int FEAT_PLAIN_BIT = 0;
    localparam int FEAT_SIG_BIT   = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NO_PAD = 2'd1,
        CAUSE_LABEL  = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_PLAIN = 2'd1,
        MODE_SIG   = 2'd2
    } mode_e;

    typedef struct packed {
        logic valid;
        logic indirect;
        logic is_pad;
    } retire_t;

    typedef struct packed {
        logic   fire;
        cause_e cause;
    } verdict_t;

    // Signature scheme wins when both scheme bits are set.
    function automatic mode_e pick_mode(input logic present,
                                        input logic plain_bit,
                                        input logic sig_bit);
        if (!present)     return MODE_OFF;
        else if (sig_bit) return MODE_SIG;
        else if (plain_bit) return MODE_PLAIN;
        else              return MODE_OFF;
    endfunction

    // Verdict for one retiring instruction while the pad state is armed.
    function automatic verdict_t judge(input logic    armed,
                                       input retire_t r,
                                       input logic    mismatch);
        verdict_t v;
        v.fire  = 1'b0;
        v.cause = CAUSE_NONE;
        if (armed && r.valid) begin
            if (!r.is_pad) begin
                v.fire  = 1'b1;
                v.cause = CAUSE_NO_PAD;
            end else if (mismatch) begin
                v.fire  = 1'b1;
                v.cause = CAUSE_LABEL;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/lpad_mode_decode.sv
module lpad_mode_decode
    import lpad_pkg::*;
#(
    parameter int FEAT_W = 3
) (
    input  logic              present,
    input  logic [FEAT_W-1:0] feature,
    output mode_e             mode,
    output logic              enabled,
    output logic              labeled
);
    logic unused_feature_bits;

    assign unused_feature_bits = ^feature;
    assign mode    = pick_mode(present, feature[FEAT_PLAIN_BIT], feature[FEAT_SIG_BIT]);
    assign enabled = (mode != MODE_OFF);
    assign labeled = (mode == MODE_SIG);
endmodule

// File: rtl/lpad_label_match.sv
module lpad_label_match #(
    parameter int LABEL_W     = 20,
    parameter bit LABEL_CHECK = 1'b1
) (
    input  logic               labeled,
    input  logic [LABEL_W-1:0] pad_label,
    input  logic [LABEL_W-1:0] exp_label,
    output logic               mismatch
);
    generate
        if (LABEL_CHECK) begin : g_check
            logic pad_nonzero;
            logic differs;
            assign pad_nonzero = |pad_label;
            assign differs     = (pad_label != exp_label);
            assign mismatch    = labeled && pad_nonzero && differs;
        end else begin : g_nocheck
            logic unused_labels;
            assign unused_labels = labeled ^ (^pad_label) ^ (^exp_label);
            assign mismatch      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/lpad_track.sv
module lpad_track
    import lpad_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enabled,
    input  retire_t rt,
    input  logic    mismatch,
    output logic    fault,
    output cause_e  cause
);
    logic     armed_q;
    logic     armed_d;
    verdict_t verdict;

    assign verdict = judge(armed_q && enabled, rt, mismatch);

    always_comb begin
        armed_d = armed_q;
        if (!enabled)
            armed_d = 1'b0;
        else if (rt.valid)
            armed_d = rt.indirect && !verdict.fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            fault   <= 1'b0;
            cause   <= CAUSE_NONE;
        end else begin
            armed_q <= armed_d;
            fault   <= verdict.fire;
            cause   <= verdict.fire ? verdict.cause : CAUSE_NONE;
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);
    a_r4_cause_on_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> (cause == CAUSE_NO_PAD || cause == CAUSE_LABEL));
    a_r12_quiet_cause: assert property (@(posedge clk) disable iff (rst)
        !fault |-> (cause == CAUSE_NONE));
    a_r6_fault_needs_arm: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(armed_q));
    a_r10_disable_drops: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> !armed_q);
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (armed_q && enabled && !rt.valid) |=> armed_q);
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
    import lpad_pkg::*;
#(
    parameter int LABEL_W     = 20,
    parameter int FEAT_W      = 3,
    parameter bit LABEL_CHECK = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rt_valid,
    input  logic               rt_indirect,
    input  logic               rt_is_pad,
    input  logic [LABEL_W-1:0] rt_pad_label,
    input  logic [LABEL_W-1:0] exp_label,
    input  logic               cfg_present,
    input  logic [FEAT_W-1:0]  cfg_feature,
    output logic               fault,
    output logic [1:0]         fault_cause
);
    mode_e   mode;
    logic    enabled;
    logic    labeled;
    logic    mismatch;
    retire_t rt;
    cause_e  cause;
    logic    unused_mode;

    assign rt.valid    = rt_valid;
    assign rt.indirect = rt_indirect;
    assign rt.is_pad   = rt_is_pad;
    assign unused_mode = ^mode;

    lpad_mode_decode #(.FEAT_W(FEAT_W)) u_mode (
        .present (cfg_present),
        .feature (cfg_feature),
        .mode    (mode),
        .enabled (enabled),
        .labeled (labeled)
    );

    lpad_label_match #(.LABEL_W(LABEL_W), .LABEL_CHECK(LABEL_CHECK)) u_label (
        .labeled   (labeled),
        .pad_label (rt_pad_label),
        .exp_label (exp_label),
        .mismatch  (mismatch)
    );

    lpad_track u_track (
        .clk      (clk),
        .rst      (rst),
        .enabled  (enabled),
        .rt       (rt),
        .mismatch (mismatch),
        .fault    (fault),
        .cause    (cause)
    );

    assign fault_cause = cause;

    a_r2_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_present |=> !fault);
    a_r3_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg_feature[FEAT_PLAIN_BIT] && !cfg_feature[FEAT_SIG_BIT]) |=> !fault);
endmodule

// File: tb/lpad_guard_test.sv
`timescale 1ns/1ps
module lpad_guard_test;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          rt_valid, rt_indirect, rt_is_pad;
    logic [LW-1:0] rt_pad_label, exp_label;
    logic          cfg_present;
    logic [2:0]    cfg_feature;
    logic          fault;
    logic [1:0]    fault_cause;

    int vectors = 0;
    int miscompares = 0;
    logic m_armed = 1'b0;

    always #2 clk = ~clk;

    lpad_guard #(.LABEL_W(LW), .FEAT_W(3), .LABEL_CHECK(1'b1)) uut (
        .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_indirect(rt_indirect),
        .rt_is_pad(rt_is_pad), .rt_pad_label(rt_pad_label), .exp_label(exp_label),
        .cfg_present(cfg_present), .cfg_feature(cfg_feature),
        .fault(fault), .fault_cause(fault_cause)
    );

    function automatic logic [2:0] predict(input logic armed, input logic v,
                                           input logic pad, input logic [LW-1:0] pl,
                                           input logic [LW-1:0] el, input logic pres,
                                           input logic [2:0] feat);
        logic en, sig;
        en  = pres && (feat[0] || feat[2]);
        sig = feat[2];
        if (!(en && armed && v)) return 3'b000;
        if (!pad) return 3'b101;
        if (sig && pl != 0 && pl != el) return 3'b110;
        return 3'b000;
    endfunction

    task automatic check(input string tag, input logic [2:0] exp);
        vectors++;
        if ({fault, fault_cause} !== exp) begin
            miscompares++;
            $display("FAIL %s: fault/cause actual %b/%0d expected %b/%0d",
                     tag, fault, fault_cause, exp[2], exp[1:0]);
        end
    endtask

    // Called at a falling edge; drives one cycle and checks the result one edge later.
    task automatic step(input string tag, input logic v, input logic ind,
                        input logic pad, input logic [LW-1:0] pl,
                        input logic [LW-1:0] el, input logic pres,
                        input logic [2:0] feat);
        logic [2:0] exp;
        logic en;
        rt_valid = v; rt_indirect = ind; rt_is_pad = pad;
        rt_pad_label = pl; exp_label = el; cfg_present = pres; cfg_feature = feat;
        exp = predict(m_armed, v, pad, pl, el, pres, feat);
        en  = pres && (feat[0] || feat[2]);
        if (!en) m_armed = 1'b0;
        else if (v) m_armed = ind && !exp[2];
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        #(4.0 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rt_valid = 0; rt_indirect = 0; rt_is_pad = 0;
        rt_pad_label = 0; exp_label = 0; cfg_present = 1; cfg_feature = 3'b001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", 3'b000);
        step("R1 no arm after reset", 1, 0, 0, 0, 0, 1, 3'b001);

        // R2 absent extension
        step("R2 jump", 1, 1, 0, 0, 0, 0, 3'b101);
        step("R2 non-pad", 1, 0, 0, 0, 0, 0, 3'b101);
        // R3 present, not activated (bit 1 only)
        step("R3 jump", 1, 1, 0, 0, 0, 1, 3'b010);
        step("R3 non-pad", 1, 0, 0, 0, 0, 1, 3'b010);
        // R4 missing pad
        step("R4 jump", 1, 1, 0, 0, 0, 1, 3'b001);
        step("R4 non-pad", 1, 0, 0, 0, 0, 1, 3'b001);
        // R9 pulse ends, state cleared
        step("R9 second non-pad", 1, 0, 0, 0, 0, 1, 3'b001);
        // R5 idle cycles hold the state
        step("R5 jump", 1, 1, 0, 0, 0, 1, 3'b001);
        step("R5 idle", 0, 0, 0, 0, 0, 1, 3'b001);
        step("R5 idle", 0, 0, 0, 0, 0, 1, 3'b001);
        step("R5 non-pad", 1, 0, 0, 0, 0, 1, 3'b001);
        // R6 direct transfer never arms
        step("R6 direct", 1, 0, 0, 0, 0, 1, 3'b001);
        step("R6 non-pad", 1, 0, 0, 0, 0, 1, 3'b001);
        // R7 unlabeled scheme ignores labels
        step("R7 jump", 1, 1, 0, 0, 0, 1, 3'b001);
        step("R7 pad 5 vs 3", 1, 0, 1, 4'd5, 4'd3, 1, 3'b001);
        // R8 signature scheme
        step("R8 jump", 1, 1, 0, 0, 0, 1, 3'b100);
        step("R8 mismatch", 1, 0, 1, 4'd5, 4'd3, 1, 3'b100);
        step("R8 jump", 1, 1, 0, 0, 0, 1, 3'b100);
        step("R8 equal", 1, 0, 1, 4'd9, 4'd9, 1, 3'b100);
        step("R8 jump", 1, 1, 0, 0, 0, 1, 3'b100);
        step("R8 zero wildcard", 1, 0, 1, 4'd0, 4'd7, 1, 3'b100);
        // R10 deactivate while armed
        step("R10 jump", 1, 1, 0, 0, 0, 1, 3'b001);
        step("R10 disabled", 1, 0, 0, 0, 0, 0, 3'b001);
        step("R10 re-enabled non-pad", 1, 0, 0, 0, 0, 1, 3'b001);
        // R11 both scheme bits: signature wins
        step("R11 jump", 1, 1, 0, 0, 0, 1, 3'b101);
        step("R11 mismatch", 1, 0, 1, 4'd2, 4'd6, 1, 3'b101);

        // Random mix, fixed seed
        begin
            int unsigned s;
            logic pres;
            logic [2:0] feat;
            s = $urandom(32'h5EED);
            pres = 1; feat = 3'b100;
            for (int i = 0; i < 4000; i++) begin
                logic v, ind, pad;
                logic [LW-1:0] pl, el;
                if ($urandom_range(0, 49) == 0) begin
                    pres = ($urandom_range(0, 5) != 0);
                    feat = 3'($urandom_range(0, 7));
                end
                v   = ($urandom_range(0, 3) != 0);
                ind = ($urandom_range(0, 2) == 0);
                pad = ($urandom_range(0, 1) == 0);
                pl  = LW'($urandom_range(0, 15));
                el  = LW'($urandom_range(0, 15));
                step("R4/R7/R8/R11 random", v, ind, pad, pl, el, pres, feat);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule